// File: doc/BRIEF.md
# Two-Dimensional Priority Bus Arbiter with Grant Chains

This block decides which device on a shared bus becomes bus owner. Devices are split into priority levels. Each level has one request line, driven as the OR of the wishes of all devices fitted on that level. Each level also has one grant line. That grant line runs through the devices of the level as a chain, starting at the device nearest the arbiter.

The arbiter registers the level request lines. From that registered copy it issues a grant to at most one level: the lowest-numbered level that is requesting. The grant then ripples down the chain of that level. The first fitted device that wants the bus keeps the grant. A device that does not want the bus passes the grant on. A slot with no device fitted passes nothing, so any device behind such a gap can never be granted.

A level keeps its grant for as long as its registered request line stays high. After that line drops there is one idle cycle before the grant is evaluated again. A lock input from the current master blocks any new grant while it is high.

Top module: `prio_chain_arbiter`

## Requirements
- R1: While reset is held, and on the first cycle after it, every device grant and every level grant is low.
- R2: A device index is level*SLOTS+slot, and slot 0 is nearest the arbiter. A level's request is the OR of the want inputs of its fitted slots. A want driven before clock edge k gives a grant that is visible after edge k+1, and not before.
- R3: When the arbiter issues a grant, it goes to the lowest-numbered level whose registered request is high.
- R4: Within the granted level, the lowest-numbered fitted slot that wants the bus is granted, and no slot behind it is granted.
- R5: A fitted slot that does not want the bus passes the level grant on to the next slot with no added cycle.
- R6: A slot whose fitted bit is 0 is never granted, and its want does not raise the level request. No slot behind it on the same level is ever granted, even while that level holds the grant.
- R7: A level grant stays on the same level while that level's registered request is high, even if a higher-priority level starts requesting.
- R8: Once a level's registered request is low, its grant drops at the next edge. No new grant is issued at that same edge.
- R9: While the lock input is high at a clock edge, no new level grant is issued at that edge. A grant that already exists is not removed by the lock.
- R10: At most one level grant is high, and at most one device grant is high, in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_want | input | LEVELS*SLOTS | Per-device wish to own the bus |
| slot_fitted | input | LEVELS*SLOTS | 1 when a device is fitted in that chain slot |
| master_locked | input | 1 | Current master cannot be interrupted; blocks new grants |
| dev_granted | output | LEVELS*SLOTS | Per-device grant at the end of the chain ripple |
| level_granted | output | LEVELS | One-hot grant issued by the arbiter to a level |

## Verification
Two events can meet in one cycle: the lock rising, and a request being registered for the first time. The bench raises the lock and a want on the same falling edge. It then checks that no level grant appears for several cycles, and that the grant appears exactly one edge after the lock drops. A second collision is a grant release while a higher-priority level is already waiting. The bench checks that there is one empty cycle and that the grant then goes to the waiting higher-priority level.

// File: rtl/arb_pkg.sv
package arb_pkg;
   localparam int unsigned MAX_LEVELS = 32;
   localparam int unsigned MAX_SLOTS  = 64;

   // isolate lowest set bit of a vector of at most MAX_LEVELS bits
   function automatic logic [MAX_LEVELS-1:0] lowest_one(input logic [MAX_LEVELS-1:0] v);
      return v & (~v + 1'b1);
   endfunction
endpackage

// File: rtl/chain_cell.sv
module chain_cell (
   input  logic grant_in,
   input  logic want,
   input  logic fitted,
   output logic taken,
   output logic grant_out
);
   // absent slot: neither keeps nor forwards the grant
   assign taken     = grant_in & fitted & want;
   assign grant_out = grant_in & fitted & ~want;
endmodule

// File: rtl/grant_chain.sv
module grant_chain #(
   parameter int unsigned SLOTS = 4
) (
   input  logic             grant_in,
   input  logic [SLOTS-1:0] want,
   input  logic [SLOTS-1:0] fitted,
   output logic [SLOTS-1:0] granted,
   output logic             req_line
);
   logic [SLOTS:0] ripple;

   assign ripple[0] = grant_in;

   for (genvar s = 0; s < SLOTS; s++) begin : g_cell
      chain_cell u_cell (
         .grant_in (ripple[s]),
         .want     (want[s]),
         .fitted   (fitted[s]),
         .taken    (granted[s]),
         .grant_out(ripple[s+1])
      );
   end

   // shared wired-OR request, only fitted devices can pull it
   assign req_line = |(want & fitted);
endmodule

// File: rtl/level_arbiter.sv
module level_arbiter #(
   parameter int unsigned LEVELS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEVELS-1:0] req_line,
   input  logic              hold_off,
   output logic [LEVELS-1:0] level_grant
);
   localparam int unsigned PW = arb_pkg::MAX_LEVELS;

   logic [LEVELS-1:0] req_q;
   logic [LEVELS-1:0] sel_q;
   logic [LEVELS-1:0] pick;
   logic [PW-1:0]     req_wide;
   logic [PW-1:0]     pick_wide;
   logic              owner_gone;

   assign req_wide   = PW'(req_q);
   assign pick_wide  = arb_pkg::lowest_one(req_wide);
   assign pick       = pick_wide[LEVELS-1:0];
   assign owner_gone = (sel_q & req_q) == '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= '0;
         sel_q <= '0;
      end else begin
         req_q <= req_line;
         if (|sel_q) begin
            if (owner_gone) sel_q <= '0;
         end else if (!hold_off && |req_q) begin
            sel_q <= pick;
         end
      end
   end

   assign level_grant = sel_q;

   // R10
   one_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_q));

   // R9
   lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|sel_q) |-> !$past(hold_off));

   // R7
   hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sel_q & req_q)) |=> (sel_q == $past(sel_q)));

   // R8
   release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|sel_q) && ((sel_q & req_q) == '0)) |=> (sel_q == '0));

   // R3
   top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|sel_q) |-> (((sel_q - 1'b1) & $past(req_q)) == '0));
endmodule

// File: rtl/prio_chain_arbiter.sv
module prio_chain_arbiter #(
   parameter int unsigned LEVELS = 3,
   parameter int unsigned SLOTS  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [LEVELS*SLOTS-1:0]  dev_want,
   input  logic [LEVELS*SLOTS-1:0]  slot_fitted,
   input  logic                     master_locked,
   output logic [LEVELS*SLOTS-1:0]  dev_granted,
   output logic [LEVELS-1:0]        level_granted
);
   localparam int unsigned NDEV = LEVELS * SLOTS;

   if (LEVELS < 1 || LEVELS > arb_pkg::MAX_LEVELS) begin : g_bad_levels
      $error("LEVELS out of range");
   end
   if (SLOTS < 1 || SLOTS > arb_pkg::MAX_SLOTS) begin : g_bad_slots
      $error("SLOTS out of range");
   end

   logic [LEVELS-1:0] req_lines;

   level_arbiter #(.LEVELS(LEVELS)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_line   (req_lines),
      .hold_off   (master_locked),
      .level_grant(level_granted)
   );

   for (genvar l = 0; l < LEVELS; l++) begin : g_level
      grant_chain #(.SLOTS(SLOTS)) u_chain (
         .grant_in(level_granted[l]),
         .want    (dev_want[l*SLOTS +: SLOTS]),
         .fitted  (slot_fitted[l*SLOTS +: SLOTS]),
         .granted (dev_granted[l*SLOTS +: SLOTS]),
         .req_line(req_lines[l])
      );

      // R4
      lvl_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|dev_granted[l*SLOTS +: SLOTS]) |-> level_granted[l]);
   end

   // R10
   one_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_granted));

   // R6
   unfitted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_granted & ~slot_fitted) == NDEV'(0));
endmodule

// File: tb/prio_chain_arbiter_tb.sv
module prio_chain_arbiter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LV = 3;
   localparam int SL = 4;
   localparam int ND = LV * SL;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [ND-1:0] dev_want = '0;
   logic [ND-1:0] slot_fitted = '1;
   logic          master_locked = 1'b0;
   logic [ND-1:0] dev_granted;
   logic [LV-1:0] level_granted;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_chain_arbiter #(.LEVELS(LV), .SLOTS(SL)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .dev_want     (dev_want),
      .slot_fitted  (slot_fitted),
      .master_locked(master_locked),
      .dev_granted  (dev_granted),
      .level_granted(level_granted)
   );

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [ND-1:0] act, input logic [ND-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [ND-1:0] dbit(input int l, input int s);
      return ND'(1) << (l*SL + s);
   endfunction

   function automatic logic [ND-1:0] lbit(input int l);
      return ND'(1) << l;
   endfunction

   task automatic settle_idle();
      dev_want = '0;
      master_locked = 1'b0;
      slot_fitted = '1;
      wait_neg(3);
   endtask

   task automatic t_reset();
      wait_neg(2);
      check("R1 dev in reset", dev_granted, '0);
      check("R1 lvl in reset", ND'(level_granted), '0);
      rst_n = 1'b1;
      wait_neg(1);
      check("R1 dev after reset", dev_granted, '0);
   endtask

   task automatic t_single();
      dev_want = dbit(1, 2);
      wait_neg(1);
      check("R2 not yet", ND'(level_granted), '0);
      wait_neg(1);
      check("R2 level", ND'(level_granted), lbit(1));
      check("R2 device", dev_granted, dbit(1, 2));
      settle_idle();
   endtask

   task automatic t_chain();
      dev_want = dbit(1, 1) | dbit(1, 3);
      wait_neg(2);
      check("R4 nearest wins", dev_granted, dbit(1, 1));
      dev_want = dbit(1, 3);
      #1;
      check("R5 pass through", dev_granted, dbit(1, 3));
      wait_neg(1);
      check("R7 level kept", ND'(level_granted), lbit(1));
      check("R5 still granted", dev_granted, dbit(1, 3));
      settle_idle();
   endtask

   task automatic t_level_prio();
      dev_want = dbit(2, 0) | dbit(0, 3);
      wait_neg(2);
      check("R3 lowest level", ND'(level_granted), lbit(0));
      check("R3 device", dev_granted, dbit(0, 3));
      settle_idle();
   endtask

   task automatic t_hold_and_release();
      dev_want = dbit(2, 1);
      wait_neg(2);
      check("R3 lone level", ND'(level_granted), lbit(2));
      dev_want = dbit(2, 1) | dbit(0, 0);
      wait_neg(3);
      check("R7 no preempt", ND'(level_granted), lbit(2));
      check("R7 device kept", dev_granted, dbit(2, 1));
      dev_want = dbit(0, 0);
      wait_neg(1);
      check("R8 held one edge", ND'(level_granted), lbit(2));
      wait_neg(1);
      check("R8 idle gap", ND'(level_granted), '0);
      wait_neg(1);
      check("R8 regrant", ND'(level_granted), lbit(0));
      check("R10 single dev", dev_granted, dbit(0, 0));
      settle_idle();
   endtask

   task automatic t_lock();
      master_locked = 1'b1;
      dev_want = dbit(1, 0);
      wait_neg(4);
      check("R9 blocked", ND'(level_granted), '0);
      master_locked = 1'b0;
      wait_neg(1);
      check("R9 after unlock", ND'(level_granted), lbit(1));
      master_locked = 1'b1;
      wait_neg(2);
      check("R9 grant kept", dev_granted, dbit(1, 0));
      dev_want = dbit(2, 2);
      wait_neg(4);
      check("R9 no new grant", ND'(level_granted), '0);
      master_locked = 1'b0;
      wait_neg(1);
      check("R9 grant resumes", dev_granted, dbit(2, 2));
      settle_idle();
   endtask

   task automatic t_gap();
      slot_fitted = ~dbit(0, 1);
      dev_want = dbit(0, 1);
      wait_neg(3);
      check("R6 absent ignored", ND'(level_granted), '0);
      dev_want = dbit(0, 1) | dbit(0, 2);
      wait_neg(2);
      check("R6 level held", ND'(level_granted), lbit(0));
      for (int i = 0; i < 5; i++) begin
         check("R6 beyond gap", dev_granted, '0);
         wait_neg(1);
      end
      settle_idle();
   endtask

   initial begin
      t_reset();
      t_single();
      t_chain();
      t_level_prio();
      t_hold_and_release();
      t_lock();
      t_gap();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule